// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

The block turns bytes into asynchronous serial frames. Software-side logic writes bytes into a 16-entry queue with a one-cycle write strobe. A frame sequencer takes the oldest byte as soon as it is idle and shifts the byte out on a single line. The sequencer is paced by an oversampling tick that pulses sixteen times per bit period. Each frame starts with a low start bit and carries 5 to 8 data bits, least significant bit first. An optional parity bit follows, then a high stop interval whose length can be set.

The line-control inputs set the data length, the stop length and the parity mode. Parity can be odd, even, forced high or forced low. The sequencer captures these settings when it takes a byte, so each frame uses the settings that held when it began. A break input pulls the line low for as long as the input is held, whatever the sequencer is doing. A clear input empties the queue but leaves alone a frame that is already on the line. Two flags report when the queue can take more bytes and when all transmission has finished.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset, the serial line is high and both status flags are 1.
- R2: A frame has a start bit of 0, then the data bits with bit 0 first, then the parity bit if enabled, then a stop interval of 1. The line is 1 between frames.
- R3: The length field `len_sel_i` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent.
- R4: When `par_en_i`=1 and `par_stick_i`=0, a parity bit follows the data. With `par_odd_n_i`=0 the count of ones over the sent data bits and the parity bit is odd. With `par_odd_n_i`=1 it is even. When `par_en_i`=0 no parity bit is sent.
- R5: When `par_en_i`=1 and `par_stick_i`=1, the parity bit is a constant: 1 when `par_odd_n_i`=0 and 0 when `par_odd_n_i`=1.
- R6: Start, data and parity bits each last 16 ticks. The stop interval lasts 16 ticks when `stop_long_i`=0. When `stop_long_i`=1 it lasts 24 ticks for 5 data bits and 32 ticks for 6, 7 or 8 data bits.
- R7: While `brk_i`=1 the serial output is 0 in the same cycle. The output returns to its normal value once `brk_i` is cleared.
- R8: The queue holds 16 bytes and sends them in the order written. A write while the queue is full is dropped.
- R9: A pulse on `fifo_clr_i` discards every queued byte, and `thr_empty_o` reads 1 from the next cycle. A frame already being sent finishes normally.
- R10: `thr_empty_o` is 1 exactly when the queue is empty. `tx_empty_o` is 1 exactly when the queue is empty and no frame, including its stop interval, is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| wr_data_i | input | 8 | Byte to queue |
| fifo_clr_i | input | 1 | Discard all queued bytes |
| len_sel_i | input | 2 | Data length code (5 + code bits) |
| stop_long_i | input | 1 | Long stop interval select |
| par_en_i | input | 1 | Parity bit present |
| par_odd_n_i | input | 1 | Parity type: 0 odd, 1 even |
| par_stick_i | input | 1 | Constant parity select |
| brk_i | input | 1 | Force line low |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| txd_o | output | 1 | Serial output |
| thr_empty_o | output | 1 | Queue empty |
| tx_empty_o | output | 1 | Queue and shifter both idle |

## Verification
A bad bit counter or a wrong shift shows up within one frame as a data, parity or stop value sampled mid-bit that does not match what the bench computed. The bench counts ticks between consecutive start edges, so a stop interval that is too long or too short shows up as a tick count that is off by a whole number of ticks, on the very next frame. A queue pointer or count error shows up later: bytes come out reordered, a byte is lost, or an extra frame appears once the queue has filled or been cleared. A wrong status flag can be seen in the cycle right after a write, a clear or the last stop tick.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  localparam int unsigned MIN_DATA_BITS = 5;
endpackage

// File: rtl/sftx_fifo.sv
module sftx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o); // R9
endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter
  import sftx_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned OVS = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         avail_i,
  input  logic [W-1:0] data_i,
  input  logic [1:0]   len_i,
  input  logic         stop_long_i,
  input  logic         par_en_i,
  input  logic         par_odd_n_i,
  input  logic         par_stick_i,
  output logic         pop_o,
  output logic         busy_o,
  output logic         line_o
);
  localparam int unsigned CW = $clog2(2 * OVS + 1);
  localparam int unsigned BW = $clog2(W + 1);

  tx_state_e     state_q;
  logic [W-1:0]  shreg_q;
  logic [BW-1:0] bits_left_q;
  logic [CW-1:0] cnt_q, stop_lim_q;
  logic          par_bit_q, has_par_q;

  logic [BW-1:0] nbits;
  logic [W-1:0]  masked;
  logic          par_calc;
  logic [CW-1:0] stop_lim;
  logic          bit_done;

  assign nbits = BW'(MIN_DATA_BITS) + BW'(len_i);

  always_comb begin
    for (int i = 0; i < W; i++) masked[i] = data_i[i] && (BW'(i) < nbits);
    if (par_stick_i) par_calc = ~par_odd_n_i;
    else             par_calc = par_odd_n_i ? (^masked) : ~(^masked);
    if (!stop_long_i)                        stop_lim = CW'(OVS);
    else if (nbits == BW'(MIN_DATA_BITS))    stop_lim = CW'(OVS + OVS / 2);
    else                                     stop_lim = CW'(2 * OVS);
  end

  assign pop_o    = (state_q == ST_IDLE) && avail_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign bit_done = (state_q == ST_STOP) ? (cnt_q == stop_lim_q - CW'(1))
                                         : (cnt_q == CW'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      shreg_q     <= '0;
      bits_left_q <= '0;
      cnt_q       <= '0;
      stop_lim_q  <= CW'(OVS);
      par_bit_q   <= 1'b0;
      has_par_q   <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (avail_i) begin
        state_q     <= ST_START;
        shreg_q     <= data_i;
        bits_left_q <= nbits - BW'(1);
        cnt_q       <= '0;
        stop_lim_q  <= stop_lim;
        par_bit_q   <= par_calc;
        has_par_q   <= par_en_i;
      end
    end else if (tick_i) begin
      if (!bit_done) begin
        cnt_q <= cnt_q + CW'(1);
      end else begin
        cnt_q <= '0;
        unique case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            if (bits_left_q == '0) begin
              state_q <= has_par_q ? ST_PAR : ST_STOP;
            end else begin
              shreg_q     <= shreg_q >> 1;
              bits_left_q <= bits_left_q - BW'(1);
            end
          end
          ST_PAR:  state_q <= ST_STOP;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg_q[0];
      ST_PAR:   line_o = par_bit_q;
      default:  line_o = 1'b1;
    endcase
  end

  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !tick_i) |=> $stable(line_o)); // R6
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned OVS   = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         fifo_clr_i,
  input  logic [1:0]   len_sel_i,
  input  logic         stop_long_i,
  input  logic         par_en_i,
  input  logic         par_odd_n_i,
  input  logic         par_stick_i,
  input  logic         brk_i,
  input  logic         tick_i,
  output logic         txd_o,
  output logic         thr_empty_o,
  output logic         tx_empty_o
);
  logic [W-1:0] q_data;
  logic         q_empty, q_full, pop, busy, line;

  sftx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr_i),
    .push_i  (wr_en_i),
    .wdata_i (wr_data_i),
    .pop_i   (pop),
    .rdata_o (q_data),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  sftx_shifter #(.W(W), .OVS(OVS)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .avail_i     (!q_empty && !fifo_clr_i),
    .data_i      (q_data),
    .len_i       (len_sel_i),
    .stop_long_i (stop_long_i),
    .par_en_i    (par_en_i),
    .par_odd_n_i (par_odd_n_i),
    .par_stick_i (par_stick_i),
    .pop_o       (pop),
    .busy_o      (busy),
    .line_o      (line)
  );

  assign txd_o       = line & ~brk_i;
  assign thr_empty_o = q_empty;
  assign tx_empty_o  = q_empty & ~busy;

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !brk_i) |-> txd_o); // R10
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_full && !pop && !fifo_clr_i) |=> q_full); // R8
endmodule

// File: tb/tb_serial_frame_tx.sv
`timescale 1ns/1ps
module tb_serial_frame_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, clr = 1'b0, brk = 1'b0, tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] len_sel = 2'b11;
  logic stop_long = 1'b0, par_en = 1'b0, par_odd_n = 1'b0, par_stick = 1'b0;
  logic txd, thr_empty, tx_empty;
  logic [1:0] div = '0;
  int tick_total = 0;
  int cyc = 0;
  int vectors = 0, miscompares = 0;

  always #4 clk = ~clk;

  serial_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .fifo_clr_i(clr), .len_sel_i(len_sel), .stop_long_i(stop_long),
    .par_en_i(par_en), .par_odd_n_i(par_odd_n), .par_stick_i(par_stick),
    .brk_i(brk), .tick_i(tick), .txd_o(txd), .thr_empty_o(thr_empty),
    .tx_empty_o(tx_empty)
  );

  always @(negedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  always @(posedge clk) if (tick) tick_total <= tick_total + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] l, input logic sl, input logic pe,
                     input logic po, input logic ps);
    len_sel = l; stop_long = sl; par_en = pe; par_odd_n = po; par_stick = ps;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick(input int target);
    while (tick_total < target) @(negedge clk);
  endtask

  // Receive one frame: returns data, parity bit and tick stamp of start edge.
  task automatic recv(input int n, input bit hp, output logic [7:0] d,
                      output logic p, output int t0, output logic stop_v);
    while (txd) @(negedge clk);
    t0 = tick_total;
    d = '0; p = 1'b0;
    wait_tick(t0 + 8);
    chk(txd == 1'b0, "R2 start bit", txd, 0);
    for (int k = 0; k < n; k++) begin
      wait_tick(t0 + 16 * (k + 1) + 8);
      d[k] = txd;
    end
    if (hp) begin
      wait_tick(t0 + 16 * (n + 1) + 8);
      p = txd;
    end
    wait_tick(t0 + 16 * (n + 1 + (hp ? 1 : 0)) + 8);
    stop_v = txd;
  endtask

  task automatic t_reset;
    chk(txd == 1'b1, "R1 idle line", txd, 1);
    chk(thr_empty == 1'b1, "R1 thr_empty", thr_empty, 1);
    chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
  endtask

  task automatic t_basic;
    logic [7:0] d; logic p, s; int t0;
    cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    put(8'hA5);
    recv(8, 0, d, p, t0, s);
    chk(d == 8'hA5, "R2 data LSB first", d, 8'hA5);
    chk(s == 1'b1, "R2 stop bit", s, 1);
    chk(thr_empty == 1'b1 && tx_empty == 1'b0, "R10 flags in stop",
        {thr_empty, tx_empty}, 2'b10);
    wait_tick(t0 + 160);
    repeat (2) @(negedge clk);
    chk(tx_empty == 1'b1, "R10 tx_empty after stop", tx_empty, 1);
  endtask

  task automatic t_lengths;
    logic [7:0] pat [4] = '{8'h15, 8'h2A, 8'h55, 8'h96};
    for (int l = 0; l < 4; l++) begin
      logic [7:0] d; logic p, s; int t0;
      cfg(2'(l), 1'b0, 1'b0, 1'b0, 1'b0);
      put(pat[l]);
      recv(5 + l, 0, d, p, t0, s);
      chk(d == pat[l], "R3 data bits", d, pat[l]);
      chk(s == 1'b1, "R3 no extra bit before stop", s, 1);
      wait_tick(t0 + 16 * (6 + l) + 16);
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic one_par(input logic [1:0] l, input logic po, input logic ps,
                         input logic [7:0] b, input logic exp, input string req);
    logic [7:0] d; logic p, s; int t0;
    cfg(l, 1'b0, 1'b1, po, ps);
    put(b);
    recv(5 + int'(l), 1, d, p, t0, s);
    chk(p == exp, req, p, exp);
    chk(s == 1'b1, "R2 stop after parity", s, 1);
    wait_tick(t0 + 16 * (7 + int'(l)) + 16);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_parity;
    one_par(2'b11, 1'b0, 1'b0, 8'h03, 1'b1, "R4 odd, two ones");
    one_par(2'b11, 1'b0, 1'b0, 8'h07, 1'b0, "R4 odd, three ones");
    one_par(2'b11, 1'b1, 1'b0, 8'h07, 1'b1, "R4 even, three ones");
    one_par(2'b11, 1'b1, 1'b0, 8'h03, 1'b0, "R4 even, two ones");
    one_par(2'b00, 1'b0, 1'b0, 8'hE1, 1'b0, "R4 odd over 5 sent bits");
    one_par(2'b11, 1'b0, 1'b1, 8'h01, 1'b1, "R5 stick type0 is 1");
    one_par(2'b11, 1'b1, 1'b1, 8'h01, 1'b0, "R5 stick type1 is 0");
  endtask

  task automatic one_stop(input logic [1:0] l, input logic sl, input int exp);
    logic [7:0] d; logic p, s; int t0, t1;
    cfg(l, sl, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h5A;
    @(negedge clk);
    wr_data = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    recv(5 + int'(l), 0, d, p, t0, s);
    recv(5 + int'(l), 0, d, p, t1, s);
    chk(t1 - t0 == exp, "R6 frame length in ticks", t1 - t0, exp);
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic t_stop;
    one_stop(2'b11, 1'b0, 160);
    one_stop(2'b00, 1'b1, 120);
    one_stop(2'b10, 1'b1, 160);
  endtask

  task automatic t_break;
    cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); brk = 1'b1;
    #1;
    chk(txd == 1'b0, "R7 break same cycle", txd, 0);
    repeat (20) @(negedge clk);
    chk(txd == 1'b0, "R7 break held", txd, 0);
    brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R7 line back after break", txd, 1);
    put(8'hFF);
    wait_tick(tick_total + 40);
    @(negedge clk);
    chk(txd == 1'b1, "R7 data bit before break", txd, 1);
    brk = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R7 break during frame", txd, 0);
    brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R7 frame resumes", txd, 1);
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic t_fifo_full;
    cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 18; i++) begin
      wr_en = 1'b1; wr_data = 8'(i * 7 + 1);
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk(thr_empty == 1'b0, "R10 thr_empty low when queued", thr_empty, 0);
    for (int i = 0; i < 17; i++) begin
      logic [7:0] d; logic p, s; int t0;
      recv(8, 0, d, p, t0, s);
      chk(d == 8'(i * 7 + 1), "R8 order through full queue", d, i * 7 + 1);
    end
    wait_tick(tick_total + 200);
    @(negedge clk);
    chk(tx_empty == 1'b1 && txd == 1'b1, "R8 write while full dropped",
        {tx_empty, txd}, 2'b11);
  endtask

  task automatic t_clear;
    logic [7:0] d; logic p, s; int t0, tstart;
    bit extra;
    cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      wr_en = 1'b1; wr_data = 8'h40 + 8'(i);
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk(thr_empty == 1'b0, "R9 queue holds bytes", thr_empty, 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(thr_empty == 1'b1, "R9 thr_empty after clear", thr_empty, 1);
    recv(8, 0, d, p, t0, s);
    chk(d == 8'h40, "R9 running frame kept", d, 8'h40);
    tstart = tick_total;
    extra = 1'b0;
    while (tick_total < tstart + 200) begin
      @(negedge clk);
      if (tick_total > t0 + 160 && !txd) extra = 1'b1;
    end
    chk(extra == 1'b0, "R9 cleared bytes not sent", extra, 0);
    chk(tx_empty == 1'b1, "R10 tx_empty after clear", tx_empty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_basic;
    t_lengths;
    t_parity;
    t_stop;
    t_break;
    t_fifo_full;
    t_clear;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule